// File: doc/BRIEF.md
# Full-Duplex PAUSE Transmit Gate

This block stops the transmit side of a full-duplex Ethernet MAC from starting new frames after the receive side has decoded a PAUSE control frame. It takes a one-cycle strobe carrying the 16-bit pause time of a decoded frame, a full-duplex flag, start and end strobes from the transmitter, and a tick that marks each bit time at the current line rate. It drives a start permit to the transmit scheduler, a pause status flag, and an interrupt strobe.

The pause interval is counted in quanta of `QUANTUM_BITS` bit times. The permit falls in the cycle after a non-zero request is taken, which is well inside the one-slot-time allowance for stopping new frames. The block never aborts a frame that is already on the wire. While such a frame is still being sent, the countdown is frozen. It resumes once the frame ends, so the full requested idle time follows the frame. A request with a zero time ends the pause at once. A new request replaces the time left on the counter. Leaving full duplex cancels any pause.

Top module: `pause_tx_gate`

## Requirements
- R1: After reset, `tx_permit` is 1, `pause_active` is 0 and `pause_irq` is 0.
- R2: When `pause_valid` is sampled high with `full_duplex` high and `pause_time` = N > 0, `pause_active` is 1 and `tx_permit` is 0 from the next cycle on.
- R3: With no frame in flight, a pause of N quanta ends after exactly N*`QUANTUM_BITS` sampled `bit_tick` pulses, counted from the cycle after the request. `pause_active` then returns to 0 and `tx_permit` to 1.
- R4: A request with `pause_time` = 0 clears the pause in the next cycle, even if a pause is active.
- R5: A request taken during an active pause reloads the counter with the new time and restarts the bit-time count. The remaining time is not added to it.
- R6: Between a `tx_start` strobe and the following `tx_end` strobe, the countdown is held. The block drives no abort signal. Counting resumes in the cycle after `tx_end`.
- R7: While `full_duplex` is 0, `pause_valid` has no effect on `pause_active`, `tx_permit` or `pause_irq`.
- R8: When `full_duplex` is sampled low during a pause, the pause is cleared in the next cycle.
- R9: `pause_irq` pulses high for one cycle, in the cycle after a request taken in full duplex with `irq_en` high. This holds for any pause time, including 0. With `irq_en` low, the strobe stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pause_valid | input | 1 | One-cycle strobe: a valid PAUSE frame was decoded |
| pause_time | input | TIME_W | Requested pause in quanta, valid with the strobe |
| full_duplex | input | 1 | Link is in full-duplex mode |
| tx_start | input | 1 | Transmitter began a frame |
| tx_end | input | 1 | Transmitter finished a frame |
| bit_tick | input | 1 | One pulse per bit time at the current speed |
| irq_en | input | 1 | Enables the interrupt strobe |
| tx_permit | output | 1 | Scheduler may start a new frame |
| pause_active | output | 1 | Pause state is active |
| pause_irq | output | 1 | One-cycle interrupt on PAUSE reception |

## Verification
All three outputs come from registers loaded at the clock edge that samples a request. The bench drives inputs and samples outputs on the falling edge. After the strobe's rising edge, it therefore reads `pause_active`, `tx_permit` and `pause_irq` at the very next falling edge. The bench holds `bit_tick` high so that every rising edge counts one bit time, and it uses a quantum of 8. It expects the release at the rising edge numbered N*8 after the request. It checks the outputs one falling edge before and one after that edge. For a frame in flight, it expects the release 8 edges after the `tx_end` edge, whatever time passed while the frame was busy.

// File: rtl/pause_gate_pkg.sv
package pause_gate_pkg;
  localparam int DEF_TIME_W       = 16;
  localparam int DEF_QUANTUM_BITS = 512;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_LOAD  = 2'd1,
    CMD_CLEAR = 2'd2
  } timer_cmd_e;
endpackage

// File: rtl/pause_frame_tracker.sv
module pause_frame_tracker (
  input  logic clk,
  input  logic rst,
  input  logic tx_start,
  input  logic tx_end,
  output logic frame_busy
);
  always_ff @(posedge clk) begin
    if (rst)           frame_busy <= 1'b0;
    else if (tx_start) frame_busy <= 1'b1;
    else if (tx_end)   frame_busy <= 1'b0;
  end

  // R6: a frame start is seen as busy in the following cycle
  a_r6_busy_after_start: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> frame_busy);
endmodule

// File: rtl/pause_quanta_timer.sv
module pause_quanta_timer
  import pause_gate_pkg::*;
#(
  parameter int TIME_W       = DEF_TIME_W,
  parameter int QUANTUM_BITS = DEF_QUANTUM_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  timer_cmd_e        cmd,
  input  logic [TIME_W-1:0] load_val,
  input  logic              count_en,
  input  logic              bit_tick,
  output logic              active
);
  localparam int PRE_W = (QUANTUM_BITS > 1) ? $clog2(QUANTUM_BITS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(QUANTUM_BITS - 1);

  logic [PRE_W-1:0]  bit_cnt;
  logic [TIME_W-1:0] quanta;
  logic              step;
  logic              wrap;

  assign step = active && count_en && bit_tick;
  assign wrap = step && (bit_cnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst || cmd == CMD_CLEAR) begin
      active  <= 1'b0;
      quanta  <= '0;
      bit_cnt <= '0;
    end else if (cmd == CMD_LOAD) begin
      active  <= (load_val != '0);
      quanta  <= load_val;
      bit_cnt <= '0;
    end else if (step) begin
      bit_cnt <= wrap ? '0 : bit_cnt + 1'b1;
      if (wrap) begin
        quanta <= quanta - 1'b1;
        if (quanta == TIME_W'(1)) active <= 1'b0;
      end
    end
  end

  // R5: a load places the new value in the counter
  a_r5_reload_value: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_LOAD) |=> (quanta == $past(load_val)) && (bit_cnt == '0));
  // R4: a zero load leaves the pause inactive
  a_r4_zero_ends: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_LOAD && load_val == '0) |=> !active);
  // R6: while counting is held, the remaining time does not move
  a_r6_hold_frozen: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_NONE && !count_en) |=> $stable(quanta) && $stable(bit_cnt));
endmodule

// File: rtl/pause_tx_gate.sv
module pause_tx_gate
  import pause_gate_pkg::*;
#(
  parameter int TIME_W       = DEF_TIME_W,
  parameter int QUANTUM_BITS = DEF_QUANTUM_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pause_valid,
  input  logic [TIME_W-1:0] pause_time,
  input  logic              full_duplex,
  input  logic              tx_start,
  input  logic              tx_end,
  input  logic              bit_tick,
  input  logic              irq_en,
  output logic              tx_permit,
  output logic              pause_active,
  output logic              pause_irq
);
  timer_cmd_e cmd;
  logic       frame_busy;
  logic       take;

  assign take = pause_valid && full_duplex;

  always_comb begin
    if (!full_duplex) cmd = CMD_CLEAR;
    else if (take)    cmd = CMD_LOAD;
    else              cmd = CMD_NONE;
  end

  pause_frame_tracker u_track (
    .clk        (clk),
    .rst        (rst),
    .tx_start   (tx_start),
    .tx_end     (tx_end),
    .frame_busy (frame_busy)
  );

  pause_quanta_timer #(
    .TIME_W       (TIME_W),
    .QUANTUM_BITS (QUANTUM_BITS)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .load_val (pause_time),
    .count_en (!frame_busy),
    .bit_tick (bit_tick),
    .active   (pause_active)
  );

  assign tx_permit = !pause_active;

  always_ff @(posedge clk) begin
    if (rst) pause_irq <= 1'b0;
    else     pause_irq <= take && irq_en;
  end

  // R7 and R8: outside full duplex the pause is never active
  a_r8_half_duplex_clear: assert property (@(posedge clk) disable iff (rst)
    !full_duplex |=> !pause_active);
  // R9: the interrupt only follows a request received in full duplex
  a_r9_irq_source: assert property (@(posedge clk) disable iff (rst)
    pause_irq |-> $past(pause_valid && full_duplex && irq_en));
  // R2: a non-zero request blocks new frames in the next cycle
  a_r2_block_next: assert property (@(posedge clk) disable iff (rst)
    (pause_valid && full_duplex && pause_time != '0) |=> !tx_permit);
endmodule

// File: tb/pause_tx_gate_tb.sv
module pause_tx_gate_tb;
  localparam int TW = 16;
  localparam int Q  = 8;

  logic clk = 1'b0;
  logic rst;
  logic pause_valid, full_duplex, tx_start, tx_end, bit_tick, irq_en;
  logic [TW-1:0] pause_time;
  logic tx_permit, pause_active, pause_irq;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  pause_tx_gate #(.TIME_W(TW), .QUANTUM_BITS(Q)) u_dut (
    .clk(clk), .rst(rst), .pause_valid(pause_valid), .pause_time(pause_time),
    .full_duplex(full_duplex), .tx_start(tx_start), .tx_end(tx_end),
    .bit_tick(bit_tick), .irq_en(irq_en), .tx_permit(tx_permit),
    .pause_active(pause_active), .pause_irq(pause_irq));

  task automatic check(string req, string what, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0b exp %0b", req, what, got, exp);
    end
  endtask

  task automatic wait_edges(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_pause(logic [TW-1:0] t);
    pause_valid = 1'b1; pause_time = t;
    @(negedge clk);
    pause_valid = 1'b0; pause_time = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1; wait_edges(2); rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "permit", tx_permit, 1'b1);
    check("R1", "active", pause_active, 1'b0);
    check("R1", "irq", pause_irq, 1'b0);
  endtask

  task automatic t_basic();
    send_pause(16'd3);
    check("R2", "active", pause_active, 1'b1);
    check("R2", "permit", tx_permit, 1'b0);
    wait_edges(3*Q - 1);
    check("R3", "before end", pause_active, 1'b1);
    wait_edges(1);
    check("R3", "released", tx_permit, 1'b1);
  endtask

  task automatic t_zero();
    send_pause(16'd20);
    wait_edges(5);
    send_pause(16'd0);
    check("R4", "zero clears", pause_active, 1'b0);
    check("R4", "permit", tx_permit, 1'b1);
  endtask

  task automatic t_reload();
    send_pause(16'd5);
    wait_edges(10);
    send_pause(16'd2);
    wait_edges(2*Q - 1);
    check("R5", "before end", pause_active, 1'b1);
    wait_edges(1);
    check("R5", "released", pause_active, 1'b0);
  endtask

  task automatic t_in_flight();
    tx_start = 1'b1; @(negedge clk); tx_start = 1'b0;
    send_pause(16'd1);
    check("R2", "permit low mid-frame", tx_permit, 1'b0);
    wait_edges(3*Q);
    check("R6", "held while busy", pause_active, 1'b1);
    tx_end = 1'b1; @(negedge clk); tx_end = 1'b0;
    wait_edges(Q - 1);
    check("R6", "before end", pause_active, 1'b1);
    wait_edges(1);
    check("R6", "released", pause_active, 1'b0);
  endtask

  task automatic t_half_duplex();
    irq_en = 1'b1;
    full_duplex = 1'b0; @(negedge clk);
    send_pause(16'd4);
    check("R7", "ignored active", pause_active, 1'b0);
    check("R7", "ignored irq", pause_irq, 1'b0);
    check("R7", "ignored permit", tx_permit, 1'b1);
    full_duplex = 1'b1; @(negedge clk);
    send_pause(16'd30);
    wait_edges(2);
    full_duplex = 1'b0; @(negedge clk);
    check("R8", "cleared", pause_active, 1'b0);
    full_duplex = 1'b1; @(negedge clk);
    check("R8", "stays clear", pause_active, 1'b0);
    irq_en = 1'b0;
  endtask

  task automatic t_irq();
    irq_en = 1'b1;
    send_pause(16'd0);
    check("R9", "irq on zero", pause_irq, 1'b1);
    @(negedge clk);
    check("R9", "one cycle", pause_irq, 1'b0);
    irq_en = 1'b0;
    send_pause(16'd2);
    check("R9", "masked", pause_irq, 1'b0);
    send_pause(16'd0);
  endtask

  initial begin
    rst = 1'b1; pause_valid = 1'b0; pause_time = '0; full_duplex = 1'b1;
    tx_start = 1'b0; tx_end = 1'b0; bit_tick = 1'b1; irq_en = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_zero();
    t_reload();
    t_in_flight();
    t_half_duplex();
    t_irq();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got hung exp done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule